// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a three-wire serial slave that holds eight configuration registers of unequal width for a signal-processing front end. A host frames each transfer by pulling the load strobe low, toggles the serial clock and presents data on the serial data input. Each frame opens with a five-bit header: three address bits, a read/write select and a test bit. For a write, register data follows, least significant bit first. The bits land in shadow registers. The active copies driven on the parallel outputs change only when the strobe rises, and every register that was fully loaded in the frame changes in the same cycle.

A write frame can run on past the end of the addressed register. Once exactly the width of the current register has been shifted in, the write pointer moves to the next address, so one frame can load several adjacent registers. A read frame sends the addressed register back on a separate serial output, one bit per falling edge of the serial clock. A soft-reset bit in the operation register returns every register to its default. A power-on window, counted in system clock cycles, blocks all writes and commits while a busy flag is high.

All serial inputs are sampled by the system clock `clk_i`, which must run several times faster than the serial clock.

Top module: `sreg_slave`

## Requirements
- R1: After `rst_ni` is released, every register output is 0 except the clamp level output, which is 0x80. `busy_o` is high for exactly `POR_CYCLES` clock cycles and then stays low.
- R2: Bits are taken on rising serial-clock edges while `sload_i` is low. Header bit order is A0, A1, A2, read-not-write (0 = write), test. The target address is A0 + 2*A1 + 4*A2.
- R3: Register data is sent LSB first. Widths by address are 0: 11 (operation), 1: 10 (VGA gain), 2: 8 (clamp level), 3: 10 (control), 4-7: 6 (pixel gains 0-3, packed into `pix_gain_o` at bit offset 6*(address-4)).
- R4: Register outputs do not change during a frame. On the first clock edge after `sload_i` rises, every register loaded in that frame changes at once.
- R5: In a write frame, the address steps up by one after exactly the current register's width in data bits. Data bits after address 7 is complete are ignored.
- R6: A register that received fewer data bits than its width before `sload_i` rose keeps its previous value.
- R7: Committing an operation value with bit 4 set returns every register, including the operation register, to its R1 default.
- R8: In a read frame (read-not-write = 1), `sdo_oe_o` rises and `sdo_o` shows bit 0 of the addressed active register after the 5th falling serial-clock edge. The next bit follows on each later falling edge, and `sdo_o` is 0 once the register's width is exceeded. `sdo_oe_o` is low outside this phase. A read frame changes no register.
- R9: While `busy_o` is high, write data and strobe rises have no effect on any register.
- R10: A frame whose test bit is 1 writes nothing and never raises `sdo_oe_o`.
- R11: While `sload_i` is high, serial-clock edges are ignored and the frame state is held in reset, so the next frame starts cleanly at header bit A0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset; starts the power-on window |
| sck_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data in |
| sload_i | input | 1 | Load strobe: low frames a transfer, rising edge commits |
| sdo_o | output | 1 | Serial readback data |
| sdo_oe_o | output | 1 | Readback output enable |
| busy_o | output | 1 | High during the power-on window |
| op_mode_o | output | 11 | Active operation register |
| vga_gain_o | output | 10 | Active VGA gain register |
| clamp_lvl_o | output | 8 | Active clamp level register |
| ctrl_o | output | 10 | Active control register |
| pix_gain_o | output | 24 | Four active 6-bit pixel gain registers |

## Verification
Each serial bit is taken on the first clock edge after a rising serial clock. The parallel outputs change on the first clock edge after the strobe rises. Readback data is registered on the first clock edge after a falling serial clock. The bench holds each pin level for two clock periods and samples two cycles after each edge, so every check reads a settled value. Outputs are also checked just before the strobe rises, so an early update would show up as a miscompare.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int NREG      = 8;
  localparam int AW        = 3;
  localparam int MAXW      = 11;
  localparam int IW        = 4;
  localparam int HDR_BITS  = 5;
  localparam int LEN_OP    = 11;
  localparam int LEN_VGA   = 10;
  localparam int LEN_CLAMP = 8;
  localparam int LEN_CTRL  = 10;
  localparam int LEN_PIX   = 6;
  localparam int NPIX      = 4;
  localparam int CLAMP_ADDR = 2;
  localparam logic [MAXW-1:0] CLAMP_DEF = MAXW'(8'h80);

  // width of the register at an address
  function automatic logic [IW-1:0] reg_len(input logic [AW-1:0] a);
    case (a)
      3'd0:    return IW'(LEN_OP);
      3'd1:    return IW'(LEN_VGA);
      3'd2:    return IW'(LEN_CLAMP);
      3'd3:    return IW'(LEN_CTRL);
      default: return IW'(LEN_PIX);
    endcase
  endfunction

  // default value of the register at an address
  function automatic logic [MAXW-1:0] reg_def(input logic [AW-1:0] a);
    return (a == AW'(CLAMP_ADDR)) ? CLAMP_DEF : '0;
  endfunction
endpackage

// File: rtl/sreg_por.sv
module sreg_por #(
  parameter int POR_CYCLES = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);
  localparam int CW = $clog2(POR_CYCLES + 2);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != CW'(POR_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (busy_o) cnt_q <= cnt_q + 1'b1;
  end

  // R1
  busy_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          sl_i,
  input  logic          sdi_i,
  input  logic          rd_bit_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          wr_bit_o,
  output logic          reg_done_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          sl_rise_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  logic          sck_q, sl_q;
  logic [2:0]    hdr_cnt_q;
  logic [AW-1:0] addr_q;
  logic          rnw_q, tst_q;
  logic [AW:0]   ptr_q;
  logic [IW-1:0] dcnt_q, rdidx_q;
  logic          rd_on_q;

  // named events
  logic sck_rise, sck_fall, hdr_done, wr_phase, rd_phase, last_bit;
  assign sck_rise  = sck_i & ~sck_q & ~sl_i;
  assign sck_fall  = ~sck_i & sck_q & ~sl_i;
  assign sl_rise_o = sl_i & ~sl_q;
  assign hdr_done  = (hdr_cnt_q == 3'(HDR_BITS));
  assign wr_phase  = hdr_done & ~rnw_q & ~tst_q & ~ptr_q[AW];
  assign rd_phase  = hdr_done & rnw_q & ~tst_q;
  assign last_bit  = (dcnt_q == reg_len(ptr_q[AW-1:0]) - 1'b1);

  assign wr_en_o    = sck_rise & wr_phase;
  assign wr_addr_o  = ptr_q[AW-1:0];
  assign wr_idx_o   = dcnt_q;
  assign wr_bit_o   = sdi_i;
  assign reg_done_o = wr_en_o & last_bit;
  assign rd_addr_o  = addr_q;
  assign rd_idx_o   = rdidx_q;
  assign sdo_oe_o   = rd_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;  sl_q <= 1'b1;
      hdr_cnt_q <= '0; addr_q <= '0; rnw_q <= 1'b0; tst_q <= 1'b0;
      ptr_q <= '0; dcnt_q <= '0; rdidx_q <= '0; rd_on_q <= 1'b0; sdo_o <= 1'b0;
    end else begin
      sck_q <= sck_i;
      sl_q  <= sl_i;
      if (sl_i) begin
        hdr_cnt_q <= '0; ptr_q <= '0; dcnt_q <= '0;
        rdidx_q <= '0; rd_on_q <= 1'b0; sdo_o <= 1'b0;
      end else begin
        if (sck_rise && !hdr_done) begin
          case (hdr_cnt_q)
            3'd0: addr_q[0] <= sdi_i;
            3'd1: addr_q[1] <= sdi_i;
            3'd2: addr_q[2] <= sdi_i;
            3'd3: rnw_q     <= sdi_i;
            default: begin
              tst_q <= sdi_i;
              ptr_q <= {1'b0, addr_q};
            end
          endcase
          hdr_cnt_q <= hdr_cnt_q + 1'b1;
        end
        if (wr_en_o) begin
          if (last_bit) begin
            ptr_q  <= ptr_q + 1'b1;
            dcnt_q <= '0;
          end else begin
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        if (sck_fall && rd_phase) begin
          sdo_o   <= rd_bit_i;
          rd_on_q <= 1'b1;
          if (rdidx_q != '1) rdidx_q <= rdidx_q + 1'b1;
        end
      end
    end
  end

  // R11
  sl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sl_i |=> (hdr_cnt_q == '0) && !sdo_oe_o);
  // R5
  beat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_q[AW] |-> (dcnt_q < reg_len(ptr_q[AW-1:0])));
  // R2
  hdr_a0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise && hdr_cnt_q == '0) |=> addr_q[0] == $past(sdi_i));
  // R10
  test_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done && tst_q) |-> !wr_en_o && !sdo_oe_o);
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int RST_BIT = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic                      wr_bit_i,
  input  logic                      reg_done_i,
  input  logic                      commit_i,
  input  logic [AW-1:0]             rd_addr_i,
  input  logic [IW-1:0]             rd_idx_i,
  output logic                      rd_bit_o,
  output logic [NREG-1:0][MAXW-1:0] active_o
);
  logic [NREG-1:0][MAXW-1:0] shadow_q, active_q;
  logic [NREG-1:0]           loaded_q;
  logic                      soft_rst;

  assign soft_rst = commit_i & loaded_q[0] & shadow_q[0][RST_BIT];
  assign active_o = active_q;
  assign rd_bit_o = (rd_idx_i < reg_len(rd_addr_i)) ? active_q[rd_addr_i][rd_idx_i] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      loaded_q <= '0;
      for (int i = 0; i < NREG; i++) active_q[i] <= reg_def(AW'(i));
    end else begin
      if (wr_en_i)    shadow_q[wr_addr_i][wr_idx_i] <= wr_bit_i;
      if (reg_done_i) loaded_q[wr_addr_i] <= 1'b1;
      if (commit_i) begin
        loaded_q <= '0;
        for (int i = 0; i < NREG; i++) begin
          if (soft_rst)         active_q[i] <= reg_def(AW'(i));
          else if (loaded_q[i]) active_q[i] <= shadow_q[i];
        end
      end
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active_q));
  // R7
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (active_q[CLAMP_ADDR] == CLAMP_DEF) && (active_q[0] == '0));

  for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
    // R3
    width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_q[g] >> reg_len(AW'(g))) == '0);
    // R6
    partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i && !loaded_q[g] && !soft_rst) |=> $stable(active_q[g]));
  end
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
  import sreg_pkg::*;
#(
  parameter int POR_CYCLES = 30000,
  parameter int RST_BIT    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   sdata_i,
  input  logic                   sload_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic                   busy_o,
  output logic [LEN_OP-1:0]      op_mode_o,
  output logic [LEN_VGA-1:0]     vga_gain_o,
  output logic [LEN_CLAMP-1:0]   clamp_lvl_o,
  output logic [LEN_CTRL-1:0]    ctrl_o,
  output logic [NPIX*LEN_PIX-1:0] pix_gain_o
);
  logic          wr_en, wr_bit, reg_done, sl_rise, rd_bit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          wr_en_g, done_g, commit_g;
  logic [NREG-1:0][MAXW-1:0] bank;

  sreg_por #(.POR_CYCLES(POR_CYCLES)) por_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o));

  sreg_frame frame_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .sl_i(sload_i), .sdi_i(sdata_i),
    .rd_bit_i(rd_bit), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_idx_o(wr_idx),
    .wr_bit_o(wr_bit), .reg_done_o(reg_done), .rd_addr_o(rd_addr), .rd_idx_o(rd_idx),
    .sl_rise_o(sl_rise), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  // power-on window gates every write path
  assign wr_en_g  = wr_en & ~busy_o;
  assign done_g   = reg_done & ~busy_o;
  assign commit_g = sl_rise & ~busy_o;

  sreg_bank #(.RST_BIT(RST_BIT)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_g), .wr_addr_i(wr_addr),
    .wr_idx_i(wr_idx), .wr_bit_i(wr_bit), .reg_done_i(done_g), .commit_i(commit_g),
    .rd_addr_i(rd_addr), .rd_idx_i(rd_idx), .rd_bit_o(rd_bit), .active_o(bank));

  assign op_mode_o   = bank[0][LEN_OP-1:0];
  assign vga_gain_o  = bank[1][LEN_VGA-1:0];
  assign clamp_lvl_o = bank[2][LEN_CLAMP-1:0];
  assign ctrl_o      = bank[3][LEN_CTRL-1:0];
  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    assign pix_gain_o[k*LEN_PIX +: LEN_PIX] = bank[4+k][LEN_PIX-1:0];
  end

  // R9
  busy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(bank));
endmodule

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb_top;
  localparam int POR = 200;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdata = 1'b0, sload = 1'b1;
  logic sdo, sdo_oe, busy;
  logic [10:0] op; logic [9:0] vga; logic [7:0] clamp; logic [9:0] ctrl; logic [23:0] pix;
  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [10:0] exp_r [8];

  always #5 clk = ~clk;

  sreg_slave #(.POR_CYCLES(POR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdata_i(sdata), .sload_i(sload),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .busy_o(busy), .op_mode_o(op), .vga_gain_o(vga),
    .clamp_lvl_o(clamp), .ctrl_o(ctrl), .pix_gain_o(pix));

  function automatic int blen(int a);
    if (a >= 4) return 6;
    if (a == 2) return 8;
    return (a == 0) ? 11 : 10;
  endfunction

  function automatic logic [10:0] obs(int a);
    case (a)
      0: return op;
      1: return {1'b0, vga};
      2: return {3'b0, clamp};
      3: return {1'b0, ctrl};
      default: return {5'b0, pix[(a-4)*6 +: 6]};
    endcase
  endfunction

  function automatic logic [10:0] pat(int a, int p);
    logic [10:0] v = 11'((a * 693 + 451) ^ (p * 1365));
    v = v & 11'((1 << blen(a)) - 1);
    if (a == 0) v[4] = 1'b0;
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic check_regs(string req);
    for (int a = 0; a < 8; a++) chk(obs(a) === exp_r[a], req, 32'(obs(a)), 32'(exp_r[a]));
  endtask

  task automatic set_defaults();
    for (int a = 0; a < 8; a++) exp_r[a] = (a == 2) ? 11'h80 : 11'h0;
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(bit b);
    sdata = b; tick(2); sck = 1'b1; tick(2); sck = 1'b0; tick(2);
  endtask
  task automatic send_hdr(int a, bit rnw, bit tb);
    pulse(a[0]); pulse(a[1]); pulse(a[2]); pulse(rnw); pulse(tb);
  endtask
  task automatic send_val(logic [10:0] v, int n);
    for (int i = 0; i < n; i++) pulse(v[i]);
  endtask
  task automatic open_f();  sload = 1'b0; tick(2); endtask
  task automatic close_f(); sload = 1'b1; tick(3); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [10:0] v;
    set_defaults();
    tick(4); rst_n = 1'b1; tick(1);
    // R1 reset state
    chk(busy === 1'b1, "R1 busy", 32'(busy), 1);
    check_regs("R1 defaults");
    // R9 write during power-on window
    open_f(); send_hdr(1, 0, 0); send_val(11'h3AB, 10); close_f();
    chk(busy === 1'b1, "R9 still busy", 32'(busy), 1);
    check_regs("R9 ignored");
    tick(POR);
    chk(busy === 1'b0, "R1 busy end", 32'(busy), 0);
    // R2 R3 R4 single writes to every address, two patterns
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 8; a++) begin
        v = pat(a, p);
        open_f(); send_hdr(a, 0, 0); send_val(v, blen(a));
        check_regs("R4 before strobe");
        close_f();
        exp_r[a] = v;
        check_regs("R3 R2 single write");
      end
    // R5 burst from every start, trailing bits past address 7
    for (int s = 0; s < 8; s++) begin
      open_f(); send_hdr(s, 0, 0);
      for (int a = s; a < 8; a++) begin
        v = pat(a, s + 3); send_val(v, blen(a)); exp_r[a] = v;
      end
      send_val(11'h7FF, 9);
      close_f();
      check_regs("R5 burst");
    end
    // R6 partial register
    open_f(); send_hdr(2, 0, 0); send_val(11'h55, 5); close_f();
    check_regs("R6 partial single");
    open_f(); send_hdr(4, 0, 0); v = 11'h2D; send_val(v, 6); send_val(11'h7, 3); close_f();
    exp_r[4] = v;
    check_regs("R6 partial burst");
    // R8 readback of every register
    for (int a = 0; a < 8; a++) begin
      open_f();
      pulse(a[0]); pulse(a[1]); pulse(a[2]); pulse(1'b1);
      chk(sdo_oe === 1'b0, "R8 oe before 5th fall", 32'(sdo_oe), 0);
      pulse(1'b0);
      chk(sdo_oe === 1'b1, "R8 oe", 32'(sdo_oe), 1);
      for (int k = 0; k < blen(a) + 2; k++) begin
        chk(sdo === ((k < blen(a)) ? exp_r[a][k] : 1'b0), "R8 bit", 32'(sdo), 32'(k));
        pulse(1'b1);
      end
      close_f();
      chk(sdo_oe === 1'b0, "R8 oe off", 32'(sdo_oe), 0);
      check_regs("R8 no change");
    end
    // R10 test bit set
    open_f(); send_hdr(3, 0, 1); send_val(11'h155, 10); close_f();
    check_regs("R10 write muted");
    open_f(); send_hdr(3, 1, 1); pulse(1'b0); pulse(1'b0);
    chk(sdo_oe === 1'b0, "R10 read muted", 32'(sdo_oe), 0);
    close_f();
    // R11 clock activity with strobe high, then aborted frame
    for (int i = 0; i < 7; i++) pulse(1'b1);
    open_f(); send_hdr(2, 0, 0); send_val(11'h3C, 8); close_f();
    exp_r[2] = 11'h3C;
    check_regs("R11 clean frame");
    open_f(); send_hdr(1, 0, 0); send_val(11'h0F, 4); close_f();
    open_f(); send_hdr(5, 0, 0); send_val(11'h2A, 6); close_f();
    exp_r[5] = 11'h2A;
    check_regs("R11 restart");
    // R7 soft reset through operation bit 4
    open_f(); send_hdr(0, 0, 0); send_val(11'h013, 11); send_val(11'h1FF, 10); close_f();
    set_defaults();
    check_regs("R7 soft reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule